// File: doc/BRIEF.md
# Memory Error Containment Controller

This block sits beside the internal memories of an Ethernet DMA engine and collects their integrity-error strobes. Each source has its own fixed response. Some sources are fatal: the statistics memory, the transmit descriptor store, the receive descriptor store and the packet store. A fatal error latches a halt of all host DMA traffic and of transmit data. The halt holds until software issues a soft reset. The register slave path lives outside this block and is never gated by it, so software can still read the cause bits while the halt is active.

Other sources are not fatal: the multicast/special-packet filter memories and a set of flexible filter memories. Their errors do not stop traffic. A filter-memory error rejects the current packet. Both kinds of filter error pulse a statistics strobe and bump a saturating counter. A flexible-filter parity error can also raise a wake event when wake filtering is enabled.

All cause bits are sticky. A per-bit mask selects which of them drive the interrupt line.

Top module: `mem_err_contain`

## Requirements
- R1: A strobe on `stat_uerr`, `txd_uerr`, `rxd_uerr` or `pbuf_uerr` sets cause bit 0, 1, 2 or 3 respectively, visible one clock later. The bit then stays set until soft reset.
- R2: Any of those four fatal strobes raises `dma_halt` and `tx_inhibit` one clock later. Both stay high until a soft reset, whatever the inputs do in the meantime.
- R3: A cycle with `soft_rst` high clears all cause bits, the halt and all counters by the next clock. Error strobes that arrive in that same cycle are ignored.
- R4: `filt_err` sets shared cause bit 4. One clock later it gives a one-cycle pulse on `pkt_reject` and on `filt_stat_inc`, and increments `filt_cnt`. It never raises `dma_halt` or `tx_inhibit`.
- R5: `flex_par_err[i]` sets cause bit 4. One clock later it pulses `flex_stat_inc[i]` and increments counter i in `flex_cnt`; counter i occupies bits `[i*CNT_W +: CNT_W]`. It causes no reject and no halt.
- R6: `wake_evt` pulses one clock after any flexible-filter parity strobe, but only if `wol_en` was high in that cycle. Otherwise it stays low.
- R7: `irq` is high exactly when some cause bit is set whose bit in `cause_mask` is 0 (0 = enabled). The mask acts combinationally.
- R8: Each counter stops at its maximum value (65535 with the default width) and does not wrap.
- R9: Non-fatal strobes that arrive while halted still update cause bit 4, the counters and the strobes.
- R10: After asynchronous reset (`rst_n` low), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, clears all state |
| stat_uerr | input | 1 | Statistics memory uncorrectable-error strobe |
| txd_uerr | input | 1 | Tx descriptor store uncorrectable-error strobe |
| rxd_uerr | input | 1 | Rx descriptor store uncorrectable-error strobe |
| pbuf_uerr | input | 1 | Packet store uncorrectable-error strobe |
| filt_err | input | 1 | Multicast/special-packet filter memory error strobe |
| flex_par_err | input | NFLEX | Flexible filter memory parity strobes |
| wol_en | input | 1 | Wake filtering enable |
| cause_mask | input | 5 | Interrupt mask per cause bit, 1 = masked |
| cause | output | 5 | Sticky cause bits: 0 stat, 1 txd, 2 rxd, 3 pbuf, 4 filter |
| irq | output | 1 | Interrupt request |
| dma_halt | output | 1 | Halt all host DMA accesses |
| tx_inhibit | output | 1 | Block transmit data |
| pkt_reject | output | 1 | Reject current packet pulse |
| filt_stat_inc | output | 1 | Filter-error statistic strobe |
| flex_stat_inc | output | NFLEX | Per-memory flexible parity statistic strobes |
| filt_cnt | output | CNT_W | Filter-error counter |
| flex_cnt | output | NFLEX*CNT_W | Packed flexible parity counters |
| wake_evt | output | 1 | Wake event pulse |

## Verification
Every registered result (cause bits, halt, inhibit, reject, strobes, counters, wake) is due exactly one clock after the edge that samples its stimulus. The only exception is `irq`, which follows the registered cause bits and the mask with no further delay. The bench drives inputs on the falling edge and samples outputs on the next falling edge, after the sampling rising edge. It compares those outputs with a behavioural model that it advances once per driven cycle, so every comparison falls exactly one clock after its stimulus. Saturation is reached by holding a strobe for more than 65535 cycles.

// File: rtl/mec_pkg.sv
package mec_pkg;
    localparam int NCAUSE   = 5;
    localparam int C_STAT   = 0;
    localparam int C_TXD    = 1;
    localparam int C_RXD    = 2;
    localparam int C_PBUF   = 3;
    localparam int C_FILT   = 4;

    typedef enum logic {ST_RUN = 1'b0, ST_HALTED = 1'b1} halt_st_e;
endpackage

// File: rtl/mec_halt_fsm.sv
module mec_halt_fsm
    import mec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic fatal,
    output logic halted
);
    halt_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst)
            st_d = ST_RUN;
        else if (fatal)
            st_d = ST_HALTED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    assign halted = (st_q == ST_HALTED);
endmodule

// File: rtl/mec_sat_ctr.sv
module mec_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mem_err_contain.sv
module mem_err_contain
    import mec_pkg::*;
#(
    parameter int NFLEX = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   stat_uerr,
    input  logic                   txd_uerr,
    input  logic                   rxd_uerr,
    input  logic                   pbuf_uerr,
    input  logic                   filt_err,
    input  logic [NFLEX-1:0]       flex_par_err,
    input  logic                   wol_en,
    input  logic [NCAUSE-1:0]      cause_mask,
    output logic [NCAUSE-1:0]      cause,
    output logic                   irq,
    output logic                   dma_halt,
    output logic                   tx_inhibit,
    output logic                   pkt_reject,
    output logic                   filt_stat_inc,
    output logic [NFLEX-1:0]       flex_stat_inc,
    output logic [CNT_W-1:0]       filt_cnt,
    output logic [NFLEX*CNT_W-1:0] flex_cnt,
    output logic                   wake_evt
);
    typedef struct packed {
        logic [NCAUSE-1:0] cause;
        logic              reject;
        logic              filt_inc;
        logic [NFLEX-1:0]  flex_inc;
        logic              wake;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic fatal_any;
    logic flex_any;
    logic halted;
    logic [NFLEX-1:0] flex_take;
    logic filt_take;

    assign fatal_any = stat_uerr | txd_uerr | rxd_uerr | pbuf_uerr;
    assign flex_any  = |flex_par_err;
    assign filt_take = filt_err & ~soft_rst;
    assign flex_take = flex_par_err & {NFLEX{~soft_rst}};

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.reject   = 1'b0;
        ctl_d.filt_inc = 1'b0;
        ctl_d.flex_inc = '0;
        ctl_d.wake     = 1'b0;
        if (soft_rst) begin
            ctl_d.cause = '0;
        end else begin
            ctl_d.cause[C_STAT] = ctl_q.cause[C_STAT] | stat_uerr;
            ctl_d.cause[C_TXD]  = ctl_q.cause[C_TXD]  | txd_uerr;
            ctl_d.cause[C_RXD]  = ctl_q.cause[C_RXD]  | rxd_uerr;
            ctl_d.cause[C_PBUF] = ctl_q.cause[C_PBUF] | pbuf_uerr;
            ctl_d.cause[C_FILT] = ctl_q.cause[C_FILT] | filt_err | flex_any;
            ctl_d.reject        = filt_err;
            ctl_d.filt_inc      = filt_err;
            ctl_d.flex_inc      = flex_par_err;
            ctl_d.wake          = wol_en & flex_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mec_halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .fatal    (fatal_any),
        .halted   (halted)
    );

    mec_sat_ctr #(.W(CNT_W)) u_filt_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .inc   (filt_take),
        .cnt   (filt_cnt)
    );

    for (genvar gi = 0; gi < NFLEX; gi++) begin : g_flex
        mec_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_rst),
            .inc   (flex_take[gi]),
            .cnt   (flex_cnt[gi*CNT_W +: CNT_W])
        );
    end

    assign cause         = ctl_q.cause;
    assign irq           = |(ctl_q.cause & ~cause_mask);
    assign dma_halt      = halted;
    assign tx_inhibit    = halted;
    assign pkt_reject    = ctl_q.reject;
    assign filt_stat_inc = ctl_q.filt_inc;
    assign flex_stat_inc = ctl_q.flex_inc;
    assign wake_evt      = ctl_q.wake;
endmodule

// File: rtl/mec_checker.sv
module mec_checker #(
    parameter int NFLEX = 4,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 stat_uerr,
    input logic                 txd_uerr,
    input logic                 rxd_uerr,
    input logic                 pbuf_uerr,
    input logic                 filt_err,
    input logic [NFLEX-1:0]     flex_par_err,
    input logic                 wol_en,
    input logic [4:0]           cause,
    input logic                 dma_halt,
    input logic                 tx_inhibit,
    input logic                 pkt_reject,
    input logic [CNT_W-1:0]     filt_cnt,
    input logic                 wake_evt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    logic fatal;
    assign fatal = stat_uerr | txd_uerr | rxd_uerr | pbuf_uerr;

    p_cause_txd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_uerr && !soft_rst) |=> cause[1]);

    p_fatal_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !soft_rst) |=> (dma_halt && tx_inhibit));

    p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && !soft_rst) |=> dma_halt);

    p_soft_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cause == 5'b0 && !dma_halt && filt_cnt == '0));

    p_reject_nohalt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_err && !fatal && !dma_halt && !soft_rst) |=> (pkt_reject && !dma_halt));

    p_wake_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wol_en || flex_par_err == '0 || soft_rst) |=> !wake_evt);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_cnt == TOP && !soft_rst) |=> filt_cnt == TOP);
endmodule

bind mem_err_contain mec_checker #(.NFLEX(NFLEX), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .stat_uerr    (stat_uerr),
    .txd_uerr     (txd_uerr),
    .rxd_uerr     (rxd_uerr),
    .pbuf_uerr    (pbuf_uerr),
    .filt_err     (filt_err),
    .flex_par_err (flex_par_err),
    .wol_en       (wol_en),
    .cause        (cause),
    .dma_halt     (dma_halt),
    .tx_inhibit   (tx_inhibit),
    .pkt_reject   (pkt_reject),
    .filt_cnt     (filt_cnt),
    .wake_evt     (wake_evt)
);

// File: tb/sim_mem_err_contain.sv
`timescale 1ns/1ps
module sim_mem_err_contain;
    localparam int PERIOD = 10;
    localparam int NF = 4;
    localparam int CW = 16;
    localparam int CMAX = 65535;

    logic clk = 0;
    logic rst_n = 0;
    logic soft_rst = 0, stat_uerr = 0, txd_uerr = 0, rxd_uerr = 0, pbuf_uerr = 0;
    logic filt_err = 0, wol_en = 0;
    logic [NF-1:0] flex_par_err = '0;
    logic [4:0] cause_mask = '0;
    logic [4:0] cause;
    logic irq, dma_halt, tx_inhibit, pkt_reject, filt_stat_inc, wake_evt;
    logic [NF-1:0] flex_stat_inc;
    logic [CW-1:0] filt_cnt;
    logic [NF*CW-1:0] flex_cnt;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model
    bit m_cause[5];
    bit m_halt, m_rej, m_finc, m_wake;
    bit m_xinc[NF];
    int m_fcnt;
    int m_xcnt[NF];

    always #(PERIOD/2) clk = ~clk;

    mem_err_contain #(.NFLEX(NF), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .stat_uerr(stat_uerr), .txd_uerr(txd_uerr), .rxd_uerr(rxd_uerr),
        .pbuf_uerr(pbuf_uerr), .filt_err(filt_err), .flex_par_err(flex_par_err),
        .wol_en(wol_en), .cause_mask(cause_mask), .cause(cause), .irq(irq),
        .dma_halt(dma_halt), .tx_inhibit(tx_inhibit), .pkt_reject(pkt_reject),
        .filt_stat_inc(filt_stat_inc), .flex_stat_inc(flex_stat_inc),
        .filt_cnt(filt_cnt), .flex_cnt(flex_cnt), .wake_evt(wake_evt)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        int ec = 0;
        int eirq = 0;
        for (int i = 0; i < 5; i++) begin
            if (m_cause[i]) ec |= (1 << i);
            if (m_cause[i] && !cause_mask[i]) eirq = 1;
        end
        chk({tag, " R1 cause"}, int'(cause), ec);
        chk({tag, " R2 dma_halt"}, int'(dma_halt), int'(m_halt));
        chk({tag, " R2 tx_inhibit"}, int'(tx_inhibit), int'(m_halt));
        chk({tag, " R4 pkt_reject"}, int'(pkt_reject), int'(m_rej));
        chk({tag, " R4 filt_stat_inc"}, int'(filt_stat_inc), int'(m_finc));
        chk({tag, " R8 filt_cnt"}, int'(filt_cnt), m_fcnt);
        for (int i = 0; i < NF; i++) begin
            chk({tag, " R5 flex_stat_inc"}, int'(flex_stat_inc[i]), int'(m_xinc[i]));
            chk({tag, " R5 flex_cnt"}, int'(flex_cnt[i*CW +: CW]), m_xcnt[i]);
        end
        chk({tag, " R6 wake_evt"}, int'(wake_evt), int'(m_wake));
        chk({tag, " R7 irq"}, int'(irq), eirq);
    endtask

    // one cycle: check previous result, drive new inputs, advance model
    task automatic tick(string tag, bit s, bit t, bit r, bit p, bit f,
                        logic [NF-1:0] fx, bit w, bit sr);
        @(negedge clk);
        compare_all(tag);
        stat_uerr = s; txd_uerr = t; rxd_uerr = r; pbuf_uerr = p;
        filt_err = f; flex_par_err = fx; wol_en = w; soft_rst = sr;
        if (sr) begin
            for (int i = 0; i < 5; i++) m_cause[i] = 0;
            m_halt = 0; m_rej = 0; m_finc = 0; m_wake = 0; m_fcnt = 0;
            for (int i = 0; i < NF; i++) begin m_xinc[i] = 0; m_xcnt[i] = 0; end
        end else begin
            if (s) m_cause[0] = 1;
            if (t) m_cause[1] = 1;
            if (r) m_cause[2] = 1;
            if (p) m_cause[3] = 1;
            if (f || fx != 0) m_cause[4] = 1;
            if (s || t || r || p) m_halt = 1;
            m_rej = f; m_finc = f;
            m_wake = w && (fx != 0);
            if (f && m_fcnt < CMAX) m_fcnt++;
            for (int i = 0; i < NF; i++) begin
                m_xinc[i] = fx[i];
                if (fx[i] && m_xcnt[i] < CMAX) m_xcnt[i]++;
            end
        end
    endtask

    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) tick(tag, 0, 0, 0, 0, 0, '0, wol_en, 0);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) m_cause[i] = 0;
        m_halt = 0; m_rej = 0; m_finc = 0; m_wake = 0; m_fcnt = 0;
        for (int i = 0; i < NF; i++) begin m_xinc[i] = 0; m_xcnt[i] = 0; end
        repeat (3) @(negedge clk);
        compare_all("R10 reset");
        rst_n = 1;
        idle("R10 idle", 2);

        // R4 filter error: reject, count, no halt
        tick("R4", 0, 0, 0, 0, 1, '0, 0, 0);
        idle("R4", 2);
        // R5 / R6 flex parity without and with wake enable
        tick("R5", 0, 0, 0, 0, 0, 4'b0101, 0, 0);
        idle("R6 off", 1);
        tick("R6", 0, 0, 0, 0, 0, 4'b1000, 1, 0);
        idle("R6", 2);
        // R7 mask cause 4 then unmask
        cause_mask = 5'b10000;
        idle("R7 masked", 2);
        cause_mask = 5'b00000;
        idle("R7 unmasked", 1);
        // R3 soft reset
        tick("R3", 0, 0, 0, 0, 0, '0, 0, 1);
        idle("R3", 2);
        // R1 / R2 each fatal source, separated by soft reset
        tick("R1 stat", 1, 0, 0, 0, 0, '0, 0, 0);
        idle("R2 hold", 3);
        tick("R3", 0, 0, 0, 0, 0, '0, 0, 1);
        tick("R1 txd", 0, 1, 0, 0, 0, '0, 0, 0);
        tick("R1 rxd", 0, 0, 1, 0, 0, '0, 0, 0);
        tick("R1 pbuf", 0, 0, 0, 1, 0, '0, 0, 0);
        idle("R2 hold", 2);
        // R9 non-fatal while halted
        tick("R9", 0, 0, 0, 0, 1, 4'b0010, 1, 0);
        idle("R9", 2);
        // R3 strobes in soft-reset cycle ignored
        tick("R3 drop", 1, 1, 1, 1, 1, 4'b1111, 1, 1);
        idle("R3 drop", 3);
        cause_mask = 5'b00001;
        tick("R7", 1, 0, 0, 0, 0, '0, 0, 0);
        idle("R7", 2);
        cause_mask = 5'b00000;
        tick("R3", 0, 0, 0, 0, 0, '0, 0, 1);
        // R8 saturation
        for (int k = 0; k < CMAX + 4; k++) tick("R8", 0, 0, 0, 0, 1, 4'b0001, 0, 0);
        idle("R8", 2);
        @(negedge clk);
        compare_all("end");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule